// File: doc/BRIEF.md
# Interrupt cause and mask controller

This block gathers 29 level-sensitive interrupt sources into a 32-bit cause register. Each source owns one cause bit, from bit 1 to bit 29. A separate 32-bit mask register enables the sources one by one. Software acknowledges a source by writing a zero into its cause bit. Writing a one leaves the bit as it is, so a read-modify-write can clear one bit without disturbing the others.

Three cause bits carry no source. Each one is a hardwired OR over a fixed set of source bits, and those sets overlap. Software can test one of them to decide which group of sources to scan first.

The pending set is the cause register ANDed with the mask register. The block reports the lowest-numbered pending source at all times. When nothing is pending it raises a spurious flag instead. It also drives a registered interrupt line to the processor.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause and mask registers read zero, `irq_o` is 0, `spurious_o` is 1 and `src_id_o` is 0.
- R2: Input `src_i[k]` sets cause bit k+1 on the next clock edge. A set wins over a write that clears the same bit in the same cycle.
- R3: A write to the cause register clears every source bit written as 0 whose source is low. Source bits written as 1 keep their value.
- R4: Cause bit 0 reads as the OR of cause bits 29..1.
- R5: Cause bit 30 reads as the OR of cause bits 29..26 and 20..1.
- R6: Cause bit 31 reads as the OR of cause bits 25..1.
- R7: Cause bits 0, 30 and 31 are read-only. Writing them has no effect.
- R8: The cause register is at address 0x00 and the mask register at 0x04. Mask bits 29..1 are writable and a mask bit of 1 enables its source. Mask bits 0, 30 and 31 read 0. Any other address reads 0, and a write to it changes nothing.
- R9: `src_id_o` gives the lowest bit number in 1..29 that is set in both cause and mask.
- R10: When no bit in 1..29 is set in both cause and mask, `spurious_o` is 1 and `src_id_o` is 0. Otherwise `spurious_o` is 0.
- R11: `irq_o` is 1 exactly one clock after cause AND mask is non-zero. It lags every update of cause or mask by one cycle.
- R12: A disabled source still latches into the cause register and reads back as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 29 | Source levels; bit k feeds cause bit k+1 |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Registered interrupt request to the processor |
| src_id_o | output | 5 | Lowest pending enabled source number |
| spurious_o | output | 1 | No enabled source pending |

## Verification
The assertions check on every cycle the following:
- the set-over-clear rule and the clear-on-zero rule of each cause bit;
- that the reported source is pending and that no lower-numbered source is pending;
- the one-cycle lag of `irq_o`;
- the pairing of the spurious flag with a zero source number.

Only the bench scenarios can show the rest:
- the read-back of the three summary bits for groups of sources that fall inside and outside each OR set;
- the read-only behaviour of those bits;
- the address decode, including unmapped addresses;
- the latching of disabled sources.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W  = 32;
  localparam int NSRC   = 29;          // cause bits 1..29
  localparam int ID_W   = $clog2(NSRC + 1);
  // summary groups (bit positions are behaviour)
  localparam logic [REG_W-1:0] GRP_ALL = 32'h3FFF_FFFE; // 29..1
  localparam logic [REG_W-1:0] GRP_HI  = 32'h3C1F_FFFE; // 29..26, 20..1
  localparam logic [REG_W-1:0] GRP_LO  = 32'h03FF_FFFE; // 25..1
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int N = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else begin
      for (int k = 0; k < N; k++) begin
        if (src_i[k])                 cause_q[k] <= 1'b1;  // set wins
        else if (wr_i && !wdata_i[k]) cause_q[k] <= 1'b0;
      end
    end
  end

  assign cause_o = cause_q;

  // R2
  src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((cause_o & $past(src_i)) == $past(src_i)));
  // R3
  zero_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((cause_o & $past(~wdata_i & ~src_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_ctrl_pkg::*;
(
  input  logic [REG_W-1:0] raw_i,
  output logic             any_o,
  output logic             hi_o,
  output logic             lo_o
);
  assign any_o = |(raw_i & GRP_ALL);
  assign hi_o  = |(raw_i & GRP_HI);
  assign lo_o  = |(raw_i & GRP_LO);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W   = 29,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        idx_o   = IDX_W'(k);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic [ID_W-1:0]   src_id_o,
  output logic              spurious_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  cause, mask_q, pend;
  logic [REG_W-1:0] raw;
  logic             s_any, s_hi, s_lo;
  logic [IDX_W-1:0] idx;
  logic             hit, irq_q;
  logic             cause_wr, mask_wr;
  logic             unused_wbits;

  assign cause_wr     = we_i && (addr_i == CAUSE_ADDR);
  assign mask_wr      = we_i && (addr_i == MASK_ADDR);
  assign unused_wbits = ^{wdata_i[31:30], wdata_i[0]};

  irq_cause_reg #(.N(NSRC)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_i    (cause_wr),
    .wdata_i (wdata_i[NSRC:1]),
    .cause_o (cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= wdata_i[NSRC:1];
  end

  assign raw = {2'b00, cause, 1'b0};

  irq_summary u_sum (
    .raw_i (raw),
    .any_o (s_any),
    .hi_o  (s_hi),
    .lo_o  (s_lo)
  );

  assign pend = cause & mask_q;

  irq_prio_enc #(.W(NSRC), .IDX_W(IDX_W)) u_enc (
    .vec_i   (pend),
    .idx_o   (idx),
    .valid_o (hit)
  );

  assign src_id_o   = hit ? ID_W'(idx) + ID_W'(1) : '0;
  assign spurious_o = !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CAUSE_ADDR)     rdata_o = {s_lo, s_hi, cause, s_any};
    else if (addr_i == MASK_ADDR) rdata_o = {2'b00, mask_q, 1'b0};
  end

  // R11
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & mask_q) != '0) |=> irq_o);
  // R11
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & mask_q) == '0) |=> !irq_o);
  // R9
  id_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spurious_o |-> (cause[src_id_o - 1] && mask_q[src_id_o - 1]));
  // R9
  id_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spurious_o |-> ((cause & mask_q & ((NSRC'(1) << (src_id_o - 1)) - NSRC'(1))) == '0));
  // R10
  spur_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |-> (src_id_o == '0 && (cause & mask_q) == '0));
endmodule

// File: tb/tb_irq_cause_ctrl.sv
module tb_irq_cause_ctrl;
  localparam real TCLK = 4.0;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [28:0] src_i = '0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, spurious_o;
  logic [4:0]  src_id_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(TCLK / 2) clk = ~clk;

  irq_cause_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .src_id_o(src_id_o), .spurious_o(spurious_o)
  );

  typedef struct packed {
    logic [31:0] pat;
    logic [31:0] msk;
    logic [4:0]  id;
    logic        spur;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h0000_0020, 32'h3FFF_FFFE, 5'd5,  1'b0},
    '{32'h0000_0088, 32'h3FFF_FFFE, 5'd3,  1'b0},
    '{32'h0000_0088, 32'h0000_0080, 5'd7,  1'b0},
    '{32'h2000_0000, 32'h3FFF_FFFE, 5'd29, 1'b0},
    '{32'h2000_0002, 32'h3FFF_FFFE, 5'd1,  1'b0},
    '{32'h0040_0000, 32'h0000_0000, 5'd0,  1'b1},
    '{32'h03E0_0000, 32'h3FFF_FFFE, 5'd21, 1'b0},
    '{32'h0000_0000, 32'h3FFF_FFFE, 5'd0,  1'b1},
    '{32'h0800_0000, 32'h0800_0000, 5'd27, 1'b0}
  };

  function automatic logic [31:0] exp_cause(input logic [31:0] p);
    logic [31:0] c;
    logic a = 0, h = 0, l = 0;
    c = '0;
    for (int b = 1; b <= 29; b++) begin
      c[b] = p[b];
      a |= p[b];
      if (b <= 20 || b >= 26) h |= p[b];
      if (b <= 25) l |= p[b];
    end
    c[0] = a; c[30] = h; c[31] = l;
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk); src_i = p[29:1];
    @(negedge clk); src_i = '0;
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 cause", d, 32'h0);
    rd(8'h04, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 spurious", {31'b0, spurious_o}, 32'h1);
    chk("R1 id", {27'b0, src_id_o}, 32'h0);

    // table: R4 R5 R6 R9 R10 R11 R12
    foreach (VECS[i]) begin
      wr(8'h00, 32'h0);
      wr(8'h04, VECS[i].msk);
      pulse(VECS[i].pat);
      rd(8'h00, d); chk($sformatf("R4_R5_R6_R12 cause v%0d", i), d, exp_cause(VECS[i].pat));
      chk($sformatf("R9 id v%0d", i), {27'b0, src_id_o}, {27'b0, VECS[i].id});
      chk($sformatf("R10 spurious v%0d", i), {31'b0, spurious_o}, {31'b0, VECS[i].spur});
      @(negedge clk); #1;
      chk($sformatf("R11 irq v%0d", i), {31'b0, irq_o}, {31'b0, !VECS[i].spur});
    end

    // R3 write-1 keeps, write-0 clears
    wr(8'h00, 32'h0);
    pulse(32'h0000_0010);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R3 keep", d, exp_cause(32'h10));
    wr(8'h00, 32'hFFFF_FFEF);
    rd(8'h00, d); chk("R3 clear", d, 32'h0);

    // R2 set wins over clear
    @(negedge clk); src_i = 29'h1 << 5;  // cause bit 6
    addr_i = 8'h00; we_i = 1'b1; wdata_i = 32'h0;
    @(negedge clk); we_i = 1'b0; src_i = '0;
    rd(8'h00, d); chk("R2 set wins", d, exp_cause(32'h40));
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R2 cleared after", d, 32'h0);

    // R7 summary bits read-only
    wr(8'h00, 32'hC000_0001);
    rd(8'h00, d); chk("R7 summary write", d, 32'h0);

    // R8 mask width and address decode
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R8 mask bits", d, 32'h3FFF_FFFE);
    wr(8'h08, 32'h0);
    rd(8'h04, d); chk("R8 unmapped write", d, 32'h3FFF_FFFE);
    rd(8'h08, d); chk("R8 unmapped read", d, 32'h0);

    // R11 lag after mask enable
    wr(8'h04, 32'h0);
    pulse(32'h0000_0100);
    @(negedge clk); #1;
    chk("R11 masked idle", {31'b0, irq_o}, 32'h0);
    wr(8'h04, 32'h0000_0100);
    #1; chk("R11 lag", {31'b0, irq_o}, 32'h0);
    @(negedge clk); #1;
    chk("R11 raised", {31'b0, irq_o}, 32'h1);
    chk("R9 id 8", {27'b0, src_id_o}, 32'd8);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule